// File: doc/BRIEF.md
# Unidirectional-Error Check Symbol Generator and Checker

This block guards a data word against unidirectional corruption. Such corruption turns some ones into zeros, or some zeros into ones, but never both in the same word. A check symbol is derived from the population count of the word. The same logic serves two purposes. It produces the symbol that a sender attaches to freshly computed results. It also rebuilds the symbol from the information bits that arrive and raises a flag when the symbol that travelled with them disagrees.

A mode parameter picks one of three symbol forms:

- The plain zero count of the word.
- The bitwise complement of the one count, held in the same width.
- A shortened form that keeps only the zero count modulo a power of two.

The shortened form saves wires, but it can no longer see every unidirectional error.

The block is purely combinational and has no handshake of its own. Information and symbol are sampled together by whatever stage surrounds it, so back-pressure is owned by that stage. A result is valid in the same cycle that its inputs are.

Top module: `ced_symbol_check`

## Requirements
- R1: With MODE = CED_B0, gen_sym_o equals the number of 0 bits in info_i, written as an unsigned binary number of width clog2(DATA_W+1).
- R2: With MODE = CED_B1, gen_sym_o equals the bitwise complement of the number of 1 bits in info_i, in width clog2(DATA_W+1). For DATA_W = 7 this gives 3'b111 for an all-zero word and 3'b000 for an all-one word.
- R3: With MODE = CED_BOSE_LIN, gen_sym_o equals the number of 0 bits in info_i modulo 2**MOD_LOG2, in width MOD_LOG2.
- R4: err_o is 1 exactly when sym_i differs from the symbol recomputed from info_i. It changes combinationally in the same cycle as the inputs.
- R5: In either full-count mode, any non-empty unidirectional error in info_i raises err_o while sym_i still holds the symbol of the original word. A non-empty unidirectional error is a set of 1-to-0 flips only, or of 0-to-1 flips only.
- R6: In the modulo mode, a unidirectional error of multiplicity 1 to 2**MOD_LOG2-1 raises err_o. An error whose multiplicity is exactly 2**MOD_LOG2 leaves err_o at 0.
- R7: A corrupted symbol with an intact information word raises err_o.
- R8: At the count extremes, CED_B0 gives 0 for an all-one word and DATA_W for an all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| info_i | input | DATA_W | Information bits to be protected or checked |
| sym_i | input | SYM_W | Check symbol delivered with the information bits |
| gen_sym_o | output | SYM_W | Symbol computed from info_i in the selected form |
| err_o | output | 1 | Mismatch between sym_i and gen_sym_o |

## Verification
The bench builds three copies of the block:

- An 8-bit zero-count checker. Its 4-bit symbol reaches the all-zero boundary value 8 and exercises random unidirectional flips of both directions.
- A 7-bit complemented one-count checker. With this width the symbol field is exactly full, so the all-one word maps to 3'b000 and the all-zero word to 3'b111.
- A 16-bit modulo-4 checker. It makes error multiplicities 1 to 4 reachable from both the all-one and the all-zero word, which shows where detection stops.

// File: rtl/ced_pkg.sv
package ced_pkg;

  typedef enum logic [1:0] {
    CED_B0       = 2'd0,
    CED_B1       = 2'd1,
    CED_BOSE_LIN = 2'd2
  } ced_mode_e;

  function automatic int sym_width(ced_mode_e mode, int data_w, int mod_log2);
    if (mode == CED_BOSE_LIN) return mod_log2;
    return $clog2(data_w + 1);
  endfunction

endpackage

// File: rtl/ced_popcnt.sv
module ced_popcnt #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CNT_W-1:0]  ones_o
);
  always_comb begin
    ones_o = '0;
    for (int i = 0; i < DATA_W; i++) begin
      ones_o = ones_o + CNT_W'(data_i[i]);
    end
  end
endmodule

// File: rtl/ced_sym_enc.sv
module ced_sym_enc #(
  parameter int               DATA_W = 8,
  parameter ced_pkg::ced_mode_e MODE = ced_pkg::CED_B0,
  parameter int               CNT_W  = 4,
  parameter int               SYM_W  = 4
) (
  input  logic [CNT_W-1:0] ones_i,
  output logic [SYM_W-1:0] sym_o
);
  logic [CNT_W-1:0] zeros;

  assign zeros = CNT_W'(DATA_W) - ones_i;

  generate
    if (MODE == ced_pkg::CED_B1) begin : g_inv_ones
      assign sym_o = SYM_W'(~ones_i);
    end else begin : g_zero_count
      // Truncating to SYM_W keeps the count modulo 2**SYM_W in the shortened mode.
      assign sym_o = SYM_W'(zeros);
    end
  endgenerate
endmodule

// File: rtl/ced_cmp.sv
module ced_cmp #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         diff_o
);
  assign diff_o = |(a_i ^ b_i);
endmodule

// File: rtl/ced_symbol_check.sv
module ced_symbol_check #(
  parameter int                 DATA_W   = 8,
  parameter ced_pkg::ced_mode_e MODE     = ced_pkg::CED_B0,
  parameter int                 MOD_LOG2 = 2,
  localparam int                SYM_W    = ced_pkg::sym_width(MODE, DATA_W, MOD_LOG2)
) (
  input  logic [DATA_W-1:0] info_i,
  input  logic [SYM_W-1:0]  sym_i,
  output logic [SYM_W-1:0]  gen_sym_o,
  output logic              err_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] ones;

  ced_popcnt #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_popcnt (
    .data_i (info_i),
    .ones_o (ones)
  );

  ced_sym_enc #(.DATA_W(DATA_W), .MODE(MODE), .CNT_W(CNT_W), .SYM_W(SYM_W)) u_enc (
    .ones_i (ones),
    .sym_o  (gen_sym_o)
  );

  ced_cmp #(.W(SYM_W)) u_cmp (
    .a_i    (gen_sym_o),
    .b_i    (sym_i),
    .diff_o (err_o)
  );
endmodule

// File: rtl/ced_symbol_check_sva.sv
module ced_symbol_check_sva #(
  parameter int                 DATA_W = 8,
  parameter ced_pkg::ced_mode_e MODE   = ced_pkg::CED_B0,
  parameter int                 SYM_W  = 4
) (
  input logic [DATA_W-1:0] info_i,
  input logic [SYM_W-1:0]  sym_i,
  input logic [SYM_W-1:0]  gen_sym_o,
  input logic              err_o
);
  int               ones_n;
  int               zeros_n;
  logic [SYM_W-1:0] exp_sym;
  logic             known;

  always_comb begin
    ones_n  = $countones(info_i);
    zeros_n = DATA_W - ones_n;
    exp_sym = SYM_W'(zeros_n);
    if (MODE == ced_pkg::CED_B1) exp_sym = ~SYM_W'(ones_n);
    known   = !$isunknown({info_i, sym_i, gen_sym_o, err_o});
  end

  generate
    if (MODE == ced_pkg::CED_B0) begin : g_b0
      always_comb if (known) p_zero_count_r1: assert (gen_sym_o == exp_sym);
    end else if (MODE == ced_pkg::CED_B1) begin : g_b1
      always_comb if (known) p_inv_ones_r2: assert (gen_sym_o == exp_sym);
    end else begin : g_bl
      always_comb if (known) p_mod_count_r3: assert (gen_sym_o == exp_sym);
    end
  endgenerate

  always_comb if (known) p_err_flag_r4: assert (err_o == (exp_sym != sym_i));
  always_comb if (known) p_symbol_fault_r7: assert ((sym_i != exp_sym) -> err_o);
endmodule

bind ced_symbol_check ced_symbol_check_sva #(
  .DATA_W (DATA_W),
  .MODE   (MODE),
  .SYM_W  (SYM_W)
) u_sva (
  .info_i    (info_i),
  .sym_i     (sym_i),
  .gen_sym_o (gen_sym_o),
  .err_o     (err_o)
);

// File: tb/ced_symbol_check_tb.sv
module ced_symbol_check_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1 R2 R3 R4";

  logic [7:0]  in8;  logic [3:0] s8;  logic [3:0] g8;  logic e8;
  logic [6:0]  in7;  logic [2:0] s7;  logic [2:0] g7;  logic e7;
  logic [15:0] in16; logic [1:0] s16; logic [1:0] g16; logic e16;

  ced_symbol_check #(.DATA_W(8), .MODE(ced_pkg::CED_B0)) dut_i (
    .info_i(in8), .sym_i(s8), .gen_sym_o(g8), .err_o(e8));
  ced_symbol_check #(.DATA_W(7), .MODE(ced_pkg::CED_B1)) dut_b1_i (
    .info_i(in7), .sym_i(s7), .gen_sym_o(g7), .err_o(e7));
  ced_symbol_check #(.DATA_W(16), .MODE(ced_pkg::CED_BOSE_LIN), .MOD_LOG2(2)) dut_bl_i (
    .info_i(in16), .sym_i(s16), .gen_sym_o(g16), .err_o(e16));

  function automatic logic [3:0] m_b0(logic [7:0] x);
    int z = 8 - $countones(x);
    return 4'(z);
  endfunction
  function automatic logic [2:0] m_b1(logic [6:0] x);
    int o = $countones(x);
    return 3'(7 - o);
  endfunction
  function automatic logic [1:0] m_bl(logic [15:0] x);
    int z = 16 - $countones(x);
    return 2'(z % 4);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference model compared on every clock.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({cur_req, " gen8"},  int'(g8),  int'(m_b0(in8)));
      check({cur_req, " err8"},  int'(e8),  int'(m_b0(in8) != s8));
      check({cur_req, " gen7"},  int'(g7),  int'(m_b1(in7)));
      check({cur_req, " err7"},  int'(e7),  int'(m_b1(in7) != s7));
      check({cur_req, " gen16"}, int'(g16), int'(m_bl(in16)));
      check({cur_req, " err16"}, int'(e16), int'(m_bl(in16) != s16));
    end
  end

  task automatic apply(logic [7:0] a, logic [3:0] sa, logic [6:0] b, logic [2:0] sb,
                       logic [15:0] c, logic [1:0] sc);
    @(posedge clk);
    #1;
    in8 = a; s8 = sa; in7 = b; s7 = sb; in16 = c; s16 = sc;
    @(negedge clk);
    #0.5;
  endtask

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1234_5678;
    in8 = '0; s8 = '0; in7 = '0; s7 = '0; in16 = '0; s16 = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8 / R2 boundaries
    cur_req = "R8";
    apply(8'hFF, 4'd0, 7'h7F, 3'd0, 16'hFFFF, 2'd0);
    check("R8 b0 all-ones", int'(g8), 0);
    check("R2 b1 all-ones", int'(g7), 0);
    check("R4 no error", int'(e8), 0);
    apply(8'h00, 4'd8, 7'h00, 3'd7, 16'h0000, 2'd0);
    check("R8 b0 all-zeros", int'(g8), 8);
    check("R2 b1 all-zeros", int'(g7), 7);
    check("R3 bl all-zeros", int'(g16), 0);

    // R1 R2 R3 R4: random words with correct and corrupted symbols
    cur_req = "R1 R2 R3 R4";
    for (int i = 0; i < 60; i++) begin
      logic [7:0] a; logic [6:0] b; logic [15:0] c;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr[7:0]; b = lfsr[14:8]; c = lfsr[31:16];
      if (i % 2 == 0) apply(a, m_b0(a), b, m_b1(b), c, m_bl(c));
      else            apply(a, m_b0(a) ^ 4'(i % 15 + 1), b, m_b1(b) ^ 3'(i % 7 + 1),
                            c, m_bl(c) ^ 2'(i % 3 + 1));
      check("R4 err8 vs symbol pattern", int'(e8), i % 2);
    end

    // R7: intact word, each symbol bit corrupted
    cur_req = "R7";
    for (int k = 0; k < 4; k++) begin
      apply(8'h5A, m_b0(8'h5A) ^ (4'd1 << k), 7'h15, m_b1(7'h15) ^ 3'((1 << k) & 7),
            16'hF0F0, m_bl(16'hF0F0) ^ 2'((1 << k) & 3));
      check("R7 b0 symbol fault", int'(e8), 1);
    end

    // R5: unidirectional errors with the original symbol
    cur_req = "R5";
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a; logic [7:0] m; logic [7:0] bad; logic [6:0] b; logic [6:0] mb; logic [6:0] badb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr[7:0]; m = lfsr[15:8]; b = lfsr[22:16]; mb = lfsr[30:24];
      if (i % 2 == 0) begin bad = a & ~m; badb = b & ~mb; end
      else            begin bad = a | m;  badb = b | mb;  end
      if (bad == a) bad = (i % 2 == 0) ? a & ~(a & -a) : a | (~a & -(~a));
      if (badb == b) badb = (i % 2 == 0) ? b & ~(b & -b) : b | (~b & -(~b));
      apply(bad, m_b0(a), badb, m_b1(b), 16'h0000, 2'd0);
      if (bad != a)  check("R5 b0 unidirectional", int'(e8), 1);
      if (badb != b) check("R5 b1 unidirectional", int'(e7), 1);
    end

    // R6: modulo-4 detection limit, both directions
    cur_req = "R6";
    for (int t = 1; t <= 4; t++) begin
      logic [15:0] msk;
      msk = 16'((1 << t) - 1);
      apply(8'hFF, 4'd0, 7'h7F, 3'd0, 16'hFFFF & ~msk, 2'd0);
      check("R6 down flips", int'(e16), (t < 4) ? 1 : 0);
      apply(8'hFF, 4'd0, 7'h7F, 3'd0, msk, 2'd0);
      check("R6 up flips", int'(e16), (t < 4) ? 1 : 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule